// File: doc/BRIEF.md
# Return-from-Exception Context Restore Controller

This block performs the restore half of an exception return for a processor core. It takes a snapshot of four architectural words: the previous-context link word, the free-context list pointer, the status word and the interrupt control word. It then runs three trap tests in a fixed priority order. If all three tests pass, it forms the address of the saved upper-context frame from a segment and offset held in the link word. It fetches sixteen words from that frame over a request/valid memory port. After the last word arrives, it presents the restored values.

The outputs are the new link word and the new status word, the fourteen restored address and data registers, and a free-list pointer that puts the consumed frame back on the free list. The block also gives an interrupt control word with its enable bit and current priority copied from the link word. Either a one-cycle done pulse or one one-cycle trap pulse ends each request. The core owns the register file, the memory and trap delivery. After a trap it sees no output change and no memory traffic.

Top module: `ctx_return_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and all three trap outputs are 0, and `link_out`, `status_out`, `free_out` and `icr_out` are zero.
- R2: If bits 19:0 of the link word are all zero, `trap_underflow` pulses for one cycle, two rising edges after `start` is sampled. This test has the highest priority, so the other two traps stay low.
- R3: If R2 does not apply and the upper-context flag (link bit 22) is 0, `trap_type` pulses alone, with the same timing as R2.
- R4: If R2 and R3 do not apply, the depth-count enable (status bit 7) is 1, and the depth counter is not zero in the sense of R5, `trap_nest` pulses alone, with the same timing as R2. When the enable bit is 0 the counter is not tested.
- R5: The depth field is status bits 6:0. The value 7'h7F counts as zero. Otherwise, let n be the number of consecutive ones counting down from bit 6. The counter is bits 6:0 ANDed with ((1 << (7-n)) - 1), and the field counts as zero when that result is zero.
- R6: A trap aborts the request: `mem_req` never rises, `done` stays low, and `link_out`, `free_out` and `icr_out` keep their previous values.
- R7: The frame base address is {link[19:16], 6'b0, link[15:0], 6'b0}. Each successive word is requested at the previous address plus 4.
- R8: The word index and the address advance only on a cycle where both `mem_req` and `mem_valid` are high. While `mem_valid` is low, the address holds, and exactly sixteen handshakes complete each restore.
- R9: Word 0 becomes `link_out` and word 1 becomes `status_out`. Words 2 to 15 fill `saved_regs[0]` to `saved_regs[13]`, which are in turn A10, A11, D8, D9, D10, D11, A12, A13, A14, A15, D12, D13, D14, D15.
- R10: `free_out` equals {free_in[31:20], link[19:0]}.
- R11: `icr_out` equals `icr_in`, except that bit 8 takes link bit 23 and bits 7:0 take link bits 31:24.
- R12: `busy` is high from the edge after `start` until the request ends. `done` is a single-cycle pulse, high two rising edges after the final handshake, and it is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a restore; sampled only while idle |
| link_in | input | 32 | Previous-context link word |
| free_in | input | 32 | Free-context list pointer |
| status_in | input | 32 | Processor status word (depth field and enable) |
| icr_in | input | 32 | Interrupt control word |
| mem_req | output | 1 | Read request, held until accepted |
| mem_addr | output | 32 | Read address |
| mem_valid | input | 1 | Read data valid; completes the handshake |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse when restored values are presented |
| trap_underflow | output | 1 | Empty link pulse |
| trap_type | output | 1 | Wrong context type pulse |
| trap_nest | output | 1 | Nonzero depth counter pulse |
| link_out | output | 32 | Restored link word |
| status_out | output | 32 | Restored status word |
| free_out | output | 32 | Updated free-list pointer |
| icr_out | output | 32 | Updated interrupt control word |
| saved_regs | output | 14x32 | Restored registers A10 to D15 in frame order |

## Verification
The inputs are captured on the first rising edge after `start`. The trap decision is registered on the second edge, so a trap pulse is due in the cycle after that second edge. The restore results and `done` come two edges after the memory handshake that carries the sixteenth word: one edge stores the word and one edge commits. The bench drives every input and samples every output 1 ns after a falling edge. For each scenario it counts falling edges from stimulus, and for each restore it checks that exactly two falling edges separate the last offered word from the observed `done`. It checks the next cycle to confirm that the pulse has dropped.

// File: rtl/ctx_return_pkg.sv
package ctx_return_pkg;
  localparam int WORD_W          = 32;
  localparam int FRAME_WORDS     = 16;
  localparam int ADDR_STEP       = WORD_W / 8;
  localparam int ADDR_ALIGN      = 6;

  // link word fields
  localparam int LINK_PTR_W      = 20;
  localparam int LINK_OFS_LSB    = 0;
  localparam int LINK_OFS_W      = 16;
  localparam int LINK_SEG_LSB    = 16;
  localparam int LINK_SEG_W      = 4;
  localparam int LINK_UPPER_BIT  = 22;
  localparam int LINK_PIE_BIT    = 23;
  localparam int LINK_PPRIO_LSB  = 24;
  localparam int PRIO_W          = 8;

  // interrupt control word fields
  localparam int ICR_IE_BIT      = 8;
  localparam int ICR_PRIO_LSB    = 0;

  // status word fields
  localparam int DEPTH_LSB       = 0;
  localparam int DEPTH_W         = 7;
  localparam int DEPTH_EN_BIT    = 7;
  localparam int STAT_KEEP_W     = DEPTH_EN_BIT + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_COMMIT
  } rfe_state_e;

  typedef struct packed {
    logic nest;
    logic ctype;
    logic underflow;
  } trap_vec_t;
endpackage

// File: rtl/ctx_trap_check.sv
module ctx_trap_check
  import ctx_return_pkg::*;
#(
  parameter int PTR_W   = LINK_PTR_W,
  parameter int DEPTH_N = DEPTH_W,
  localparam int LEAD_W = $clog2(DEPTH_N + 1)
) (
  input  logic [PTR_W-1:0]   ptr_field,
  input  logic               upper_flag,
  input  logic               depth_en,
  input  logic [DEPTH_N-1:0] depth_field,
  output trap_vec_t          traps
);
  logic [LEAD_W-1:0]  lead_ones;
  logic               run;
  logic [DEPTH_N-1:0] cnt_mask;
  logic               depth_zero;

  // count ones from the top bit downward until the first zero
  always_comb begin
    lead_ones = '0;
    run       = 1'b1;
    for (int b = DEPTH_N - 1; b >= 0; b--) begin
      if (run && depth_field[b]) lead_ones = lead_ones + 1'b1;
      else                       run       = 1'b0;
    end
  end

  // the counter occupies the bits below the leading-ones prefix
  generate
    for (genvar g = 0; g < DEPTH_N; g++) begin : g_mask
      assign cnt_mask[g] = (g < (DEPTH_N - int'(lead_ones)));
    end
  endgenerate

  assign depth_zero = (&depth_field) || ((depth_field & cnt_mask) == '0);

  // fixed priority: empty link, then wrong type, then nesting
  always_comb begin
    traps           = '0;
    traps.underflow = (ptr_field == '0);
    traps.ctype     = !traps.underflow && !upper_flag;
    traps.nest      = !traps.underflow && upper_flag && depth_en && !depth_zero;
  end
endmodule

// File: rtl/ctx_addr_gen.sv
module ctx_addr_gen
  import ctx_return_pkg::*;
#(
  parameter int SEG_W = LINK_SEG_W,
  parameter int OFS_W = LINK_OFS_W,
  parameter int ALIGN = ADDR_ALIGN,
  localparam int GAP_W = WORD_W - SEG_W - OFS_W - ALIGN
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFS_W-1:0]  ofs,
  output logic [WORD_W-1:0] base
);
  // segment on top, offset scaled by the frame size below it
  assign base = {seg, {GAP_W{1'b0}}, ofs, {ALIGN{1'b0}}};
endmodule

// File: rtl/ctx_frame_store.sv
module ctx_frame_store
  import ctx_return_pkg::*;
#(
  parameter int DEPTH = FRAME_WORDS,
  parameter int WIDTH = WORD_W,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WIDTH-1:0]            wr_data,
  output logic [DEPTH-1:0][WIDTH-1:0] frame
);
  logic [WIDTH-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_idx] <= wr_data;
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_out
      assign frame[g] = words[g];
    end
  endgenerate
endmodule

// File: rtl/ctx_return_ctrl.sv
module ctx_return_ctrl
  import ctx_return_pkg::*;
#(
  localparam int IDX_W = $clog2(FRAME_WORDS),
  localparam int NREG  = FRAME_WORDS - 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [WORD_W-1:0]            link_in,
  input  logic [WORD_W-1:0]            free_in,
  input  logic [WORD_W-1:0]            status_in,
  input  logic [WORD_W-1:0]            icr_in,
  output logic                         mem_req,
  output logic [WORD_W-1:0]            mem_addr,
  input  logic                         mem_valid,
  input  logic [WORD_W-1:0]            mem_rdata,
  output logic                         busy,
  output logic                         done,
  output logic                         trap_underflow,
  output logic                         trap_type,
  output logic                         trap_nest,
  output logic [WORD_W-1:0]            link_out,
  output logic [WORD_W-1:0]            status_out,
  output logic [WORD_W-1:0]            free_out,
  output logic [WORD_W-1:0]            icr_out,
  output logic [NREG-1:0][WORD_W-1:0]  saved_regs
);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(FRAME_WORDS - 1);
  localparam logic [WORD_W-1:0] STEP     = WORD_W'(ADDR_STEP);

  rfe_state_e                     state;
  logic [WORD_W-1:0]              link_q;
  logic [WORD_W-1:LINK_PTR_W]     free_hi_q;
  logic [STAT_KEEP_W-1:0]         stat_q;
  logic [WORD_W-1:0]              icr_q;
  logic [IDX_W-1:0]               idx_q;
  trap_vec_t                      trap_now;
  logic [WORD_W-1:0]              base_addr;
  logic [FRAME_WORDS-1:0][WORD_W-1:0] frame;
  logic [WORD_W-1:0]              icr_next;
  logic                           beat;
  logic                           unused_bits;

  assign unused_bits = ^{free_in[LINK_PTR_W-1:0], status_in[WORD_W-1:STAT_KEEP_W],
                         link_q[LINK_UPPER_BIT-1:LINK_PTR_W]};

  assign busy = (state != ST_IDLE);
  assign beat = (state == ST_READ) && mem_req && mem_valid;

  ctx_trap_check u_check (
    .ptr_field   (link_q[LINK_PTR_W-1:0]),
    .upper_flag  (link_q[LINK_UPPER_BIT]),
    .depth_en    (stat_q[DEPTH_EN_BIT]),
    .depth_field (stat_q[DEPTH_LSB +: DEPTH_W]),
    .traps       (trap_now)
  );

  ctx_addr_gen u_addr (
    .seg  (link_q[LINK_SEG_LSB +: LINK_SEG_W]),
    .ofs  (link_q[LINK_OFS_LSB +: LINK_OFS_W]),
    .base (base_addr)
  );

  ctx_frame_store u_store (
    .clk     (clk),
    .wr_en   (beat),
    .wr_idx  (idx_q),
    .wr_data (mem_rdata),
    .frame   (frame)
  );

  // interrupt enable and current priority come back from the link word
  always_comb begin
    icr_next = icr_q;
    icr_next[ICR_IE_BIT] = link_q[LINK_PIE_BIT];
    icr_next[ICR_PRIO_LSB +: PRIO_W] = link_q[LINK_PPRIO_LSB +: PRIO_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      link_q         <= '0;
      free_hi_q      <= '0;
      stat_q         <= '0;
      icr_q          <= '0;
      idx_q          <= '0;
      mem_req        <= 1'b0;
      mem_addr       <= '0;
      done           <= 1'b0;
      trap_underflow <= 1'b0;
      trap_type      <= 1'b0;
      trap_nest      <= 1'b0;
      link_out       <= '0;
      status_out     <= '0;
      free_out       <= '0;
      icr_out        <= '0;
      saved_regs     <= '0;
    end else begin
      done           <= 1'b0;
      trap_underflow <= 1'b0;
      trap_type      <= 1'b0;
      trap_nest      <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            link_q    <= link_in;
            free_hi_q <= free_in[WORD_W-1:LINK_PTR_W];
            stat_q    <= status_in[STAT_KEEP_W-1:0];
            icr_q     <= icr_in;
            state     <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (trap_now != '0) begin
            trap_underflow <= trap_now.underflow;
            trap_type      <= trap_now.ctype;
            trap_nest      <= trap_now.nest;
            state          <= ST_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= base_addr;
            idx_q    <= '0;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          if (beat) begin
            if (idx_q == LAST_IDX) begin
              mem_req <= 1'b0;
              state   <= ST_COMMIT;
            end else begin
              idx_q    <= idx_q + 1'b1;
              mem_addr <= mem_addr + STEP;
            end
          end
        end
        ST_COMMIT: begin
          link_out   <= frame[0];
          status_out <= frame[1];
          for (int i = 0; i < NREG; i++) saved_regs[i] <= frame[i+2];
          free_out   <= {free_hi_q, link_q[LINK_PTR_W-1:0]};
          icr_out    <= icr_next;
          done       <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  trap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trap_underflow, trap_type, trap_nest}));

  // R6
  trap_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_underflow || trap_type || trap_nest) |-> (!mem_req && !done && !busy));

  // R6
  trap_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_underflow || trap_type || trap_nest) |->
      ($stable(link_out) && $stable(free_out) && $stable(icr_out)));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_valid) |=> (!mem_req || (mem_addr == $past(mem_addr) + STEP)));
endmodule

// File: tb/ctx_return_ctrl_bench.sv
`timescale 1ns/1ps
module ctx_return_ctrl_bench;
  import ctx_return_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] link_in = '0, free_in = '0, status_in = '0, icr_in = '0;
  logic mem_req, mem_valid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic busy, done, trap_underflow, trap_type, trap_nest;
  logic [31:0] link_out, status_out, free_out, icr_out;
  logic [13:0][31:0] saved_regs;

  int n_run = 0, n_fail = 0;
  int neg_count = 0, last_beat_neg = 0, beats = 0;
  logic stall_en = 1'b0, stall_tgl = 1'b0;
  logic [31:0] addr_log [16];

  ctx_return_ctrl u_ctx_return_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .link_in(link_in), .free_in(free_in), .status_in(status_in), .icr_in(icr_in),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done),
    .trap_underflow(trap_underflow), .trap_type(trap_type), .trap_nest(trap_nest),
    .link_out(link_out), .status_out(status_out), .free_out(free_out), .icr_out(icr_out),
    .saved_regs(saved_regs)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h1234};
  endfunction

  // memory model: answers on falling edges, optionally every other cycle
  always @(negedge clk) begin
    neg_count = neg_count + 1;
    if (mem_req && !(stall_en && stall_tgl)) begin
      mem_valid = 1'b1;
      mem_rdata = word_at(mem_addr);
      if (beats < 16) addr_log[beats] = mem_addr;
      beats = beats + 1;
      last_beat_neg = neg_count;
    end else begin
      mem_valid = 1'b0;
    end
    stall_tgl = ~stall_tgl;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic test_reset();
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 mem_req", {31'b0, mem_req}, 32'd0);
    check("R1 traps", {29'b0, trap_nest, trap_type, trap_underflow}, 32'd0);
    check("R1 link_out", link_out, 32'd0);
    check("R1 free_out", free_out, 32'd0);
    check("R1 icr_out", icr_out, 32'd0);
  endtask

  task automatic test_restore(input string name, input logic [31:0] link, input logic [31:0] free,
                              input logic [31:0] stat, input logic [31:0] icr, input logic stall);
    logic [31:0] ea;
    bit seen;
    step();
    link_in = link; free_in = free; status_in = stat; icr_in = icr;
    stall_en = stall; beats = 0; start = 1'b1;
    step();
    start = 1'b0;
    check({"R12 busy after start ", name}, {31'b0, busy}, 32'd1);
    seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      step();
      seen = done;
      if (trap_underflow || trap_type || trap_nest) seen = 1'b1;
    end
    check({"R12 done seen ", name}, {31'b0, done}, 32'd1);
    check({"R4 no trap ", name}, {29'b0, trap_nest, trap_type, trap_underflow}, 32'd0);
    check({"R12 done latency ", name}, neg_count - last_beat_neg, 32'd2);
    check({"R8 beat count ", name}, beats, 32'd16);
    ea = {link[19:16], 6'b0, link[15:0], 6'b0};
    for (int i = 0; i < 16; i++) check({"R7 address ", name}, addr_log[i], ea + 32'(4 * i));
    check({"R9 link_out ", name}, link_out, word_at(ea));
    check({"R9 status_out ", name}, status_out, word_at(ea + 32'd4));
    for (int i = 0; i < 14; i++) check({"R9 saved_regs ", name}, saved_regs[i], word_at(ea + 32'(4 * (i + 2))));
    check({"R10 free_out ", name}, free_out, {free[31:20], link[19:0]});
    check({"R11 icr_out ", name}, icr_out, {icr[31:9], link[23], link[31:24]});
    step();
    check({"R12 done drops ", name}, {30'b0, done, busy}, 32'd0);
    stall_en = 1'b0;
  endtask

  task automatic test_trap(input string name, input logic [31:0] link, input logic [31:0] stat,
                           input logic [2:0] exp_vec);
    logic [31:0] old_link, old_free, old_icr;
    old_link = link_out; old_free = free_out; old_icr = icr_out;
    step();
    link_in = link; free_in = 32'hFFFF_FFFF; status_in = stat; icr_in = 32'hFFFF_FFFF;
    beats = 0; start = 1'b1;
    step();
    start = 1'b0;
    step();
    check({name, " trap vector"}, {29'b0, trap_nest, trap_type, trap_underflow}, {29'b0, exp_vec});
    check({"R6 no request ", name}, {31'b0, mem_req}, 32'd0);
    step();
    check({"R6 pulse ends ", name}, {28'b0, trap_nest, trap_type, trap_underflow, done}, 32'd0);
    check({"R6 no beats ", name}, beats, 32'd0);
    check({"R6 link kept ", name}, link_out, old_link);
    check({"R6 free kept ", name}, free_out, old_free);
    check({"R6 icr kept ", name}, icr_out, old_icr);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    step();
    test_reset();
    // R4: enable off with nonzero counter 7'b1000011 -> no trap
    test_restore("plain", 32'hA5C3_1234, 32'hABCD_E000, 32'h0000_0043, 32'hFFFF_0000, 1'b0);
    // R5 R8: all-ones depth field counts as zero; memory stalls every other cycle
    test_restore("stalled", 32'h1740_FFFF, 32'h1234_5678, 32'h0000_00FF, 32'h0000_01FF, 1'b1);
    // R5: 7'b1100000 -> counter bits 4:0 are zero
    test_restore("depth2", 32'h03C8_0040, 32'h0000_0000, 32'h0000_00E0, 32'h8000_0100, 1'b0);
    // R5: 7'b1111110 -> counter bit 0 is zero
    test_restore("depth6", 32'hFFCF_8001, 32'hFFFF_FFFF, 32'h0000_00FE, 32'h0000_0000, 1'b1);
    // R2: empty pointer beats the type and nest tests
    test_trap("R2 underflow", 32'h5500_0000, 32'h0000_00C3, 3'b001);
    // R3: pointer nonzero, upper flag clear
    test_trap("R3 type", 32'h0080_0010, 32'h0000_00C3, 3'b010);
    // R4: upper flag set, counter 7'b1000011 nonzero, enable set
    test_trap("R4 nest", 32'h0040_0010, 32'h0000_00C3, 3'b100);
    // R5: 7'b1111101 -> counter bits 1:0 equal 1, nonzero
    test_trap("R5 nest narrow", 32'h0040_0010, 32'h0000_00FD, 3'b100);
    // restore still works after traps
    test_restore("after traps", 32'h2AC7_0F0F, 32'h0F0F_0000, 32'h0000_0001, 32'h1234_5678, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule